// File: doc/BRIEF.md
# Pruned Multi-Stage CIC Decimator

This block lowers the sample rate of one real, signed sample stream by a fixed integer ratio, for example one branch of a quadrature mixer. It is a single cascaded integrator-comb structure: a chain of integrators clocked by every accepted input sample, a counter that picks one integrator result out of every RATE, and a chain of first-difference combs that run only on those picked results. The whole decimation is done by this one structure rather than by several small filters in series.

The full-precision word grows by log2 of the ratio for every order, so at large ratios it reaches 45 to 66 bits. To save storage and carry-chain length, each stage may keep only the upper part of that word. A per-stage drop count is set at elaboration, and a value loses its extra low bits as it passes into the next stage. Integrators are allowed to wrap, because the combs remove the wrap. The output word is the top OUT_W bits of the final comb, with a one-cycle valid strobe.

Top module: `cic_decim`

## Requirements
- R1: While `rst` is high at a clock edge, after that edge `out_valid` is 0 and `out_data` is 0. All filter state and the sample counter restart from zero.
- R2: `out_valid` pulses for exactly one clock per RATE accepted inputs. It is never high on two cycles in a row, and `out_data` changes only on a cycle where `out_valid` is high.
- R3: `out_valid` rises ORDER clock edges after the edge that accepted every RATE-th input sample counted since reset.
- R4: With every drop count set to zero, each output equals bits [FULL_W-1 -: OUT_W] of a full-precision model. In that model FULL_W = IN_W + ORDER*clog2(RATE), the integrators are each delayed by one sample and fed by the previous integrator's old value, and the combs have differential delay 1.
- R5: A constant input x with zero drop counts settles to x*RATE^ORDER shifted right by FULL_W-OUT_W (x*64 for IN_W=18, ORDER=3, RATE=8, OUT_W=24).
- R6: The drop table is a parameter with 8 bits per stage. Stage s sits in bits [8s+7:8s], integrators come first (s=0..ORDER-1) and combs after (s=ORDER..2*ORDER-1). Stage s holds FULL_W minus its count bits. Every value passing into stage s loses its low (count[s] - count[s-1]) bits by truncation toward minus infinity. The input loses count[0] bits. The output is the top OUT_W bits of the last stage.
- R7: Integrators wrap modulo their register width. After a long full-scale constant input that wraps them, the output is still the exact value of R5, including the most negative input.
- R8: A cycle with `in_valid` low is ignored: `in_data` on that cycle changes no output, and it does not advance the rate counter.
- R9: A synchronous reset in the middle of a decimation period discards the partial period. The next output follows RATE new accepted inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input sample qualifier |
| in_data | input | IN_W | Signed two's-complement input sample |
| out_valid | output | 1 | One-cycle strobe per decimated sample |
| out_data | output | OUT_W | Signed top bits of the last comb stage |

## Verification
The hardest case to reach from the ports is integrator wraparound. It has to be shown that the combs still cancel it, so the bench drives hundreds of full-scale constant samples of both signs. Those runs push the last integrator far past its width before the exact settled value is checked. A second hard case is a decimation phase that is not aligned with any cycle pattern. Here gapped `in_valid` carries garbage data, and a reset lands in the middle of a period. Every output of both the unpruned and the pruned instance is compared against an arithmetic model in the bench, and so is its arrival cycle.

// File: rtl/cic_decim.sv
module cic_decim #(
  parameter int IN_W  = 18,
  parameter int OUT_W = 24,
  parameter int ORDER = 4,
  parameter int RATE  = 4096,
  parameter logic [255:0] PRUNE = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [IN_W-1:0]  in_data,
  output logic             out_valid,
  output logic [OUT_W-1:0] out_data
);
  function automatic int drop(input int s);
    return int'(PRUNE[8*s +: 8]);
  endfunction

  localparam int FULL_W = IN_W + ORDER * $clog2(RATE);
  localparam int CNT_W  = $clog2(RATE);
  localparam int NS     = 2 * ORDER;
  localparam int WL     = FULL_W - drop(NS - 1);

  logic [CNT_W-1:0] cnt;
  logic             dec_q;
  wire              at_last = (cnt == CNT_W'(RATE - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= '0;
      dec_q <= 1'b0;
    end else begin
      dec_q <= in_valid && at_last;
      if (in_valid) cnt <= at_last ? '0 : cnt + CNT_W'(1);
    end
  end

  wire [FULL_W-1:0] in_ext = {{(FULL_W-IN_W){in_data[IN_W-1]}}, in_data};

  for (genvar j = 0; j < ORDER; j++) begin : g_int
    localparam int W = FULL_W - drop(j);
    logic [W-1:0] acc;
    logic [W-1:0] din;
    if (j == 0) begin : g_src
      assign din = W'(in_ext >> drop(0));
    end else begin : g_src
      localparam int WP = FULL_W - drop(j - 1);
      assign din = W'(g_int[j-1].acc >> (WP - W));
    end
    always_ff @(posedge clk) begin
      if (rst)           acc <= '0;
      else if (in_valid) acc <= acc + din;
    end
  end

  for (genvar j = 0; j < ORDER; j++) begin : g_comb
    localparam int W  = FULL_W - drop(ORDER + j);
    localparam int WP = FULL_W - drop(ORDER + j - 1);
    logic [W-1:0] din, dly, val;
    logic         vin, vout;
    if (j == 0) begin : g_src
      assign din = W'(g_int[ORDER-1].acc >> (WP - W));
      assign vin = dec_q;
    end else begin : g_src
      assign din = W'(g_comb[j-1].val >> (WP - W));
      assign vin = g_comb[j-1].vout;
    end
    always_ff @(posedge clk) begin
      if (rst) begin
        dly  <= '0;
        val  <= '0;
        vout <= 1'b0;
      end else begin
        vout <= vin;
        if (vin) begin
          val <= din - dly;
          dly <= din;
        end
      end
    end
  end

  assign out_valid = g_comb[ORDER-1].vout;
  assign out_data  = OUT_W'(g_comb[ORDER-1].val >> (WL - OUT_W));
endmodule

module cic_decim_chk #(
  parameter int ORDER = 4,
  parameter int RATE  = 4096,
  parameter int OUT_W = 24
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic             out_valid,
  input logic [OUT_W-1:0] out_data
);
  localparam int CW = $clog2(RATE);
  logic [CW-1:0]  seen;
  logic [ORDER:0] due;
  wire            period_end = in_valid && (seen == CW'(RATE - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      seen <= '0;
      due  <= '0;
    end else begin
      if (in_valid) seen <= (seen == CW'(RATE - 1)) ? '0 : seen + CW'(1);
      due <= {due[ORDER-1:0], period_end};
    end
  end

  assert_reset_quiet_R1: assert property (@(posedge clk) rst |=> !out_valid);
  assert_single_pulse_R2: assert property (@(posedge clk) disable iff (rst)
    out_valid |=> !out_valid);
  assert_data_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> $stable(out_data));
  assert_latency_R3: assert property (@(posedge clk) disable iff (rst)
    out_valid == due[ORDER]);
endmodule

bind cic_decim cic_decim_chk #(.ORDER(ORDER), .RATE(RATE), .OUT_W(OUT_W)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .out_valid(out_valid), .out_data(out_data));

// File: tb/cic_decim_tb.sv
module cic_decim_tb;
  localparam int ORD = 3;
  localparam int RT  = 8;
  localparam int FW  = 27;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic signed [17:0] in_data = '0;
  logic        ov0, ov1;
  logic [23:0] od0;
  logic [15:0] od1;

  always #2 clk = ~clk;

  cic_decim #(.IN_W(18), .OUT_W(24), .ORDER(ORD), .RATE(RT), .PRUNE('0)) u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .out_valid(ov0), .out_data(od0));

  cic_decim #(.IN_W(18), .OUT_W(16), .ORDER(ORD), .RATE(RT),
              .PRUNE(256'h0a0908060402)) u_dut_pr (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .out_valid(ov1), .out_data(od1));

  int checks = 0, errors = 0, cyc = 0, mcnt = 0;
  string phase = "";
  longint acc[2][3], cd[2][3], cv[2][3];
  int drp[2][6] = '{'{0, 0, 0, 0, 0, 0}, '{2, 4, 6, 8, 9, 10}};
  int outw[2] = '{24, 16};
  longint eq0[$], eq1[$];
  int tq0[$], tq1[$];
  longint last0 = 0;
  logic [31:0] lfsr = 32'h1234_abcd;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  function automatic longint wrapv(input longint v, input int w);
    longint s;
    s = v <<< (64 - w);
    return s >>> (64 - w);
  endfunction

  task automatic model_clear();
    for (int m = 0; m < 2; m++)
      for (int k = 0; k < 3; k++) begin
        acc[m][k] = 0; cd[m][k] = 0; cv[m][k] = 0;
      end
    mcnt = 0;
  endtask

  task automatic model_accept(input longint x);
    for (int m = 0; m < 2; m++)
      for (int k = 2; k >= 0; k--) begin
        longint src;
        src = (k == 0) ? (x >>> drp[m][0]) : (acc[m][k-1] >>> (drp[m][k] - drp[m][k-1]));
        acc[m][k] = wrapv(acc[m][k] + src, FW - drp[m][k]);
      end
    mcnt++;
    if (mcnt == RT) begin
      mcnt = 0;
      for (int m = 0; m < 2; m++) begin
        longint y;
        for (int j = 0; j < 3; j++) begin
          int s;
          longint src;
          s = 3 + j;
          src = (j == 0) ? acc[m][2] : cv[m][j-1];
          src = wrapv(src >>> (drp[m][s] - drp[m][s-1]), FW - drp[m][s]);
          cv[m][j] = wrapv(src - cd[m][j], FW - drp[m][s]);
          cd[m][j] = src;
        end
        y = wrapv(cv[m][2] >>> (FW - outw[m] - drp[m][5]), outw[m]);
        if (m == 0) begin eq0.push_back(y); tq0.push_back(cyc + 1 + ORD); end
        else        begin eq1.push_back(y); tq1.push_back(cyc + 1 + ORD); end
      end
    end
  endtask

  always @(negedge clk) begin
    if (ov0) begin
      if (eq0.size() == 0) chk(1'b0, {"R2 extra output ", phase}, 1, 0);
      else begin
        longint e, a;
        int t;
        e = eq0.pop_front(); t = tq0.pop_front();
        a = longint'($signed(od0));
        last0 = a;
        chk(a == e, {"R4 unpruned ", phase}, a, e);
        chk(cyc == t, {"R3 latency ", phase}, cyc, t);
      end
    end
    if (ov1) begin
      if (eq1.size() == 0) chk(1'b0, {"R2 extra output pruned ", phase}, 1, 0);
      else begin
        longint e, a;
        int t;
        e = eq1.pop_front(); t = tq1.pop_front();
        a = longint'($signed(od1));
        chk(a == e, {"R6 pruned ", phase}, a, e);
        chk(cyc == t, {"R3 latency pruned ", phase}, cyc, t);
      end
    end
  end

  task automatic drive(input logic v, input logic signed [17:0] x);
    @(negedge clk);
    in_valid = v;
    in_data = x;
    if (v) model_accept(longint'(x));
  endtask

  task automatic flush(input int n);
    for (int i = 0; i < n; i++) drive(1'b0, 18'(lfsr));
  endtask

  task automatic do_reset(input int n);
    @(negedge clk);
    rst = 1'b1;
    in_valid = 1'b0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      chk(!ov0 && !ov1, "R1 valid low in reset", longint'(ov0) + longint'(ov1), 0);
      chk(od0 == 0 && od1 == 0, "R1 data zero in reset", longint'(od0) + longint'(od1), 0);
    end
    eq0.delete(); eq1.delete(); tq0.delete(); tq1.delete();
    model_clear();
    rst = 1'b0;
  endtask

  task automatic step_lfsr();
    lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(1'b0, "watchdog", cyc, 0);
    finish_run();
  end

  initial begin
    model_clear();
    do_reset(4);

    phase = "impulse";
    drive(1'b1, 18'sd1000);
    for (int i = 0; i < 63; i++) drive(1'b1, 18'sd0);
    flush(8);

    phase = "sweep";
    for (int k = 0; k < 512; k++) drive(1'b1, 18'(-131072 + k * 512 + (k % 7) * 13));
    flush(8);

    phase = "alternating";
    for (int k = 0; k < 128; k++) drive(1'b1, (k % 2) ? -18'sd131072 : 18'sd131071);
    flush(8);

    phase = "R8 gapped";
    for (int k = 0; k < 800; k++) begin
      step_lfsr();
      drive(lfsr[7] | lfsr[3], 18'(lfsr >> 5));
    end
    flush(8);

    phase = "R9 midperiod reset";
    for (int k = 0; k < 13; k++) begin step_lfsr(); drive(1'b1, 18'(lfsr)); end
    do_reset(2);
    for (int k = 0; k < 67; k++) begin step_lfsr(); drive(1'b1, 18'(lfsr)); end
    flush(8);
    chk(eq0.size() == 0 && eq1.size() == 0, "R2 outputs all delivered",
        longint'(eq0.size() + eq1.size()), 0);

    do_reset(2);
    phase = "R5 dc";
    for (int k = 0; k < 48; k++) drive(1'b1, 18'sd1000);
    flush(8);
    chk(last0 == 64000, "R5 dc settle", last0, 64000);

    do_reset(2);
    phase = "R7 wrap max";
    for (int k = 0; k < 400; k++) drive(1'b1, 18'sd131071);
    flush(8);
    chk(last0 == 64'sd8388544, "R7 wrap positive full scale", last0, 64'sd8388544);

    do_reset(2);
    phase = "R7 wrap min";
    for (int k = 0; k < 400; k++) drive(1'b1, -18'sd131072);
    flush(8);
    chk(last0 == -64'sd8388608, "R7 wrap negative full scale", last0, -64'sd8388608);
    chk(eq0.size() == 0 && eq1.size() == 0, "R2 no missing outputs",
        longint'(eq0.size() + eq1.size()), 0);

    finish_run();
  end
endmodule